// File: doc/BRIEF.md
# Timer and Interrupt Register File

This block holds the interval timer and the interrupt-controller registers of a processor's hardware I/O page. It also holds the memory data latch that the sound, timer, input and interrupt windows share. Register bits that are not implemented read back from this latch, which holds the last byte written on the bus.

The bus side uses four inputs: a window select, a register offset, read and write strobes, and write data. Read data is combinational from the current state. The timer is a 7-bit down-counter that reloads itself. A prescaler that divides the clock by `PRESCALE` drives it. When the counter runs past zero it raises a timer interrupt. That interrupt stays pending until software writes the status address.

The block combines three sources into one interrupt request: external (always idle), video (two input lines ORed together) and the timer. Each source has its own disable bit.

Top module: `tmr_irq_regs`

## Requirements
- R1: Every write (`wr_en` high), to any window, stores `wr_data` into the 8-bit data latch at that clock edge.
- R2: Window select codes are 0 sound, 1 timer, 2 input, 3 interrupt. A read of the sound window, of the input window, or of interrupt offsets 0 and 1 returns the data latch unchanged.
- R3: A write to the timer window with offset bit 0 clear loads the 7-bit reload value from `wr_data[6:0]`. A timer read returns {latch bit 7, counter[6:0]}.
- R4: A write to the timer window with offset bit 0 set sets the run flag from `wr_data[0]`. When that bit is 1, the write also copies the reload value into the counter and restarts the prescaler. When the timer is stopped, the counter holds its value.
- R5: While the timer runs, the counter steps down once every `PRESCALE` cycles. A step taken at zero reloads the counter and sets timer-pending. With reload value N, pending is first set (N+1)*`PRESCALE` cycles after the starting write.
- R6: A write to interrupt offset 2 sets the disable bits from `wr_data[2:0]`: bit 0 external, bit 1 video, bit 2 timer. A read of offset 2 returns {latch[7:3], disable bits}.
- R7: A read of interrupt offset 3 returns {latch[7:3], timer-pending, video_a OR video_b, 0}.
- R8: Any write to interrupt offset 3 clears timer-pending. If an underflow occurs in the same cycle, the clear still takes effect.
- R9: `irq_req` is high exactly when a source is pending and its disable bit is 0 (video pending or timer pending, each with its own bit).
- R10: After reset the disable bits are 0, the timer is stopped with counter and reload at 0, timer-pending is low and the latch is 0x00.
- R11: While `rd_en` is low, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win | input | 2 | Window select: 0 sound, 1 timer, 2 input, 3 interrupt |
| offs | input | 2 | Register offset inside the window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| vid_irq_a | input | 1 | First video interrupt line |
| vid_irq_b | input | 1 | Second video interrupt line |
| rd_data | output | 8 | Read data |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `win`, `offs` and `wr_data` are known whenever `wr_en` is high, and that each write lasts exactly one cycle. The bench drives strobes only from tasks that raise them for one clock and drop them straight after. The video lines are treated as levels that may change at any time, and no property ties them to bus activity. The timer is tested with a small prescaler override. That keeps the underflow cycle at a known edge count after the enabling write, and keeps the waits in the bench short.

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs #(
  parameter int PRESCALE = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] win,
  input  logic [1:0] offs,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       vid_irq_a,
  input  logic       vid_irq_b,
  output logic [7:0] rd_data,
  output logic       irq_req
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  localparam logic [1:0] W_SND = 2'd0;
  localparam logic [1:0] W_TMR = 2'd1;
  localparam logic [1:0] W_INP = 2'd2;
  localparam logic [1:0] W_IRQ = 2'd3;

  logic [7:0]    mdr;
  logic [6:0]    reload, cnt;
  logic [PW-1:0] pre;
  logic          run, tmr_pend;
  logic [2:0]    mask;

  wire tmr_wr  = wr_en && (win == W_TMR);
  wire irq_wr  = wr_en && (win == W_IRQ);
  wire ctl_wr  = tmr_wr && offs[0];
  wire tick    = run && (pre == PLAST);
  wire uflow   = tick && (cnt == 7'd0) && !ctl_wr;
  wire vid_any = vid_irq_a | vid_irq_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdr      <= 8'h00;
      reload   <= 7'd0;
      cnt      <= 7'd0;
      pre      <= '0;
      run      <= 1'b0;
      tmr_pend <= 1'b0;
      mask     <= 3'b000;
    end else begin
      if (wr_en) mdr <= wr_data;
      if (tmr_wr && !offs[0]) reload <= wr_data[6:0];
      if (ctl_wr) begin
        run <= wr_data[0];
        pre <= '0;
        if (wr_data[0]) cnt <= reload;
      end else if (run) begin
        pre <= tick ? '0 : PW'(pre + 1'b1);
        if (tick) cnt <= (cnt == 7'd0) ? reload : cnt - 7'd1;
      end
      if (irq_wr && offs == 2'd2) mask <= wr_data[2:0];
      if (irq_wr && offs == 2'd3) tmr_pend <= 1'b0;
      else if (uflow)             tmr_pend <= 1'b1;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = mdr;
    case (win)
      W_TMR: rd_mux = {mdr[7], cnt};
      W_IRQ: begin
        if (offs == 2'd2) rd_mux = {mdr[7:3], mask};
        if (offs == 2'd3) rd_mux = {mdr[7:3], tmr_pend, vid_any, 1'b0};
      end
      W_SND, W_INP: rd_mux = mdr;
      default: rd_mux = mdr;
    endcase
  end

  assign rd_data = rd_en ? rd_mux : 8'h00;
  assign irq_req = (vid_any & ~mask[1]) | (tmr_pend & ~mask[2]);
endmodule

// File: rtl/tmr_irq_regs_chk.sv
module tmr_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] win,
  input logic [1:0] offs,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] mdr,
  input logic [6:0] reload,
  input logic [6:0] cnt,
  input logic       run,
  input logic       tmr_pend,
  input logic [2:0] mask,
  input logic       irq_req
);
  // R1
  mdr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mdr == $past(wr_data));

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == 2'd1 && offs[0] && wr_data[0]) |=> (cnt == $past(reload)) && run);

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && win == 2'd1)) |=> $stable(cnt));

  // R5
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_pend) |-> $past(run));

  // R8
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == 2'd3 && offs == 2'd3) |=> !tmr_pend);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[2:1] == 2'b11) |-> !irq_req);

  // R9
  tmr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_pend && !mask[2]) |-> irq_req);
endmodule

bind tmr_irq_regs tmr_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .win(win), .offs(offs), .wr_en(wr_en),
  .wr_data(wr_data), .mdr(mdr), .reload(reload), .cnt(cnt), .run(run),
  .tmr_pend(tmr_pend), .mask(mask), .irq_req(irq_req)
);

// File: tb/tb_tmr_irq_regs.sv
`timescale 1ns/1ps
module tb_tmr_irq_regs;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] win = '0, offs = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       vid_irq_a = 1'b0, vid_irq_b = 1'b0;
  logic [7:0] rd_data;
  logic       irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_irq_regs #(.PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .win(win), .offs(offs), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .vid_irq_a(vid_irq_a),
    .vid_irq_b(vid_irq_b), .rd_data(rd_data), .irq_req(irq_req)
  );

  // {is_write, win, offs, data, expected}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'd0, 8'hA5, 8'h00},
    {1'b0, 2'd0, 2'd0, 8'h00, 8'hA5},
    {1'b0, 2'd3, 2'd0, 8'h00, 8'hA5},
    {1'b0, 2'd3, 2'd1, 8'h00, 8'hA5},
    {1'b1, 2'd3, 2'd2, 8'hF5, 8'h00},
    {1'b0, 2'd3, 2'd2, 8'h00, 8'hF5},
    {1'b1, 2'd2, 2'd0, 8'h38, 8'h00},
    {1'b0, 2'd3, 2'd2, 8'h00, 8'h3D},
    {1'b0, 2'd3, 2'd3, 8'h00, 8'h38},
    {1'b1, 2'd1, 2'd0, 8'h85, 8'h00},
    {1'b0, 2'd1, 2'd0, 8'h00, 8'h80},
    {1'b1, 2'd3, 2'd2, 8'h00, 8'h00},
    {1'b0, 2'd2, 2'd0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    win = w; offs = o; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, input logic [1:0] o, output logic [7:0] d);
    win = w; offs = o; rd_en = 1'b1;
    #0.5 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] v, hold;
    edges(3);
    rst_n = 1'b1;
    edges(1);

    // R10 reset state
    rd(2'd3, 2'd2, v); check("R10 mask/latch", v, 8'h00);
    rd(2'd1, 2'd0, v); check("R10 timer", v, 8'h00);
    rd(2'd3, 2'd3, v); check("R10 status", v, 8'h00);
    check("R10 irq_req", {7'd0, irq_req}, 8'h00);

    // R1 R2 R3 R6 R7 table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:18], VEC[i][17:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][19:18], VEC[i][17:16], v);
        check("R1/R2/R3/R6/R7 table", v, VEC[i][7:0]);
      end
    end

    // R11
    win = 2'd0; #0.5;
    check("R11 idle read", rd_data, 8'h00);

    // R4 R5 timer
    wr(2'd1, 2'd0, 8'h02);
    wr(2'd1, 2'd1, 8'h01);
    rd(2'd1, 2'd0, v); check("R4 start load", v, 8'h02);
    edges(P);
    rd(2'd1, 2'd0, v); check("R5 step", v, 8'h01);
    edges(3 * P - P - 1);
    check("R5 no early pend", {7'd0, irq_req}, 8'h00);
    edges(1);
    check("R5 R9 pend irq", {7'd0, irq_req}, 8'h01);
    rd(2'd3, 2'd3, v); check("R7 timer pend", v, 8'h04);
    rd(2'd1, 2'd0, v); check("R5 reload", v, 8'h02);

    // R8
    wr(2'd3, 2'd3, 8'h00);
    check("R8 ack irq", {7'd0, irq_req}, 8'h00);
    rd(2'd3, 2'd3, v); check("R8 ack status", v, 8'h00);

    // R9 masking
    wr(2'd3, 2'd2, 8'h04);
    edges(3 * P);
    rd(2'd3, 2'd3, v); check("R9 masked pend", v, 8'h04);
    check("R9 masked irq", {7'd0, irq_req}, 8'h00);
    vid_irq_a = 1'b1; #0.5;
    check("R9 video irq", {7'd0, irq_req}, 8'h01);
    rd(2'd3, 2'd3, v); check("R7 video a", v, 8'h06);
    vid_irq_a = 1'b0; vid_irq_b = 1'b1; #0.5;
    rd(2'd3, 2'd3, v); check("R7 video b", v, 8'h06);
    wr(2'd3, 2'd2, 8'h06);
    check("R9 all masked", {7'd0, irq_req}, 8'h00);
    rd(2'd3, 2'd2, v); check("R6 mask readback", v, 8'h06);
    vid_irq_b = 1'b0;

    // R4 halt
    wr(2'd1, 2'd1, 8'h00);
    rd(2'd1, 2'd0, hold);
    edges(5 * P);
    rd(2'd1, 2'd0, v); check("R4 halted hold", v, hold);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule